// File: doc/BRIEF.md
# SMT Reorder Buffer Capacity Allocator

This block decides how many reorder-buffer slots each hardware thread of a multithreaded core may hold. It sits beside the reorder buffer and keeps only counts: one occupancy counter per thread and one for the whole buffer. Dispatch raises an insert strobe tagged with a thread number when it writes an entry, and commit raises a retire strobe when it frees one. From these counts and a per-thread limit the block reports each thread's remaining allowance, the space left in the buffer as a whole, and a full flag. Dispatch uses these to decide whether to stall a thread.

The per-thread limit comes from a sharing policy chosen by an input. In the dynamic policy every thread may take the whole buffer. In the partitioned policy the buffer is split evenly among the configured threads. In the threshold policy each thread is capped at a programmed value. The policy, thread count and threshold are sampled in the first cycle after reset. After that the limits are adjusted only when the set of active threads changes. The limit is a guide for dispatch: the block does not refuse an insert because one thread is over its own limit. It refuses an insert only when the whole buffer is full.

Top module: `smt_rob_alloc`

## Requirements
- R1: While reset is held and in the first cycle after it, all occupancy counters are zero. `global_free` equals the entry count (32 by default), `full` and `ins_error` are 0, and every limit and per-thread free count is 0.
- R2: Policy code 0 (dynamic, with code 3 treated the same) gives every configured thread a limit equal to the entry count in the first cycle after reset.
- R3: Policy code 1 (partitioned) gives every configured thread a limit equal to the entry count divided by `cfg_threads`, rounded down.
- R4: Policy code 2 (threshold) gives every configured thread a limit equal to `threshold`.
- R5: Threads numbered `cfg_threads` or higher always have a limit of 0. Their bits in `active_mask` are ignored both in the active count and in the change detection.
- R6: Under the partitioned policy, when the configured part of `active_mask` changes to a non-empty set, every active thread's limit becomes the entry count divided by the number of active threads, rounded down. The limits of inactive threads are kept.
- R7: Under the threshold policy, when the configured active set changes to exactly one thread, that thread's limit becomes the entry count. A change to two or more active threads leaves all limits as they were. Under any policy, a change to an empty active set leaves all limits as they were.
- R8: An accepted insert adds one to the tagged thread's occupancy and to the global occupancy. A retire subtracts one from both. A retire aimed at a thread with zero occupancy is ignored. Counters update at the clock edge where the strobe is sampled.
- R9: `global_free` is the entry count minus the global occupancy. `full` is 1 exactly when `global_free` is 0.
- R10: An insert sampled while `full` is 1 is rejected and leaves the counters unchanged. `ins_error` is 1 in the following cycle, and only then.
- R11: An insert and a retire in the same cycle, with the buffer not full, leave `global_free` unchanged. When both carry the same thread number, that thread's free count is also unchanged.
- R12: A thread's free count is its limit minus its occupancy, and saturates at 0 when the occupancy exceeds a limit that has been lowered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy | input | 2 | Sharing policy: 0 dynamic, 1 partitioned, 2 threshold, 3 dynamic |
| cfg_threads | input | NW (3) | Number of configured threads |
| active_mask | input | MAX_THREADS (4) | One bit per active thread |
| threshold | input | CW (6) | Per-thread cap used by the threshold policy |
| ins_valid | input | 1 | Insert strobe |
| ins_tid | input | TW (2) | Thread number of the insert |
| ret_valid | input | 1 | Retire strobe |
| ret_tid | input | TW (2) | Thread number of the retire |
| limit_flat | output | MAX_THREADS*CW (24) | Per-thread limits; thread t occupies bits [t*CW +: CW] |
| free_flat | output | MAX_THREADS*CW (24) | Per-thread free counts, packed the same way as `limit_flat` |
| global_free | output | CW (6) | Free entries in the whole buffer |
| full | output | 1 | Global occupancy equals the entry count |
| ins_error | output | 1 | An insert was rejected in the previous cycle |

## Verification
A wrong occupancy count shows up at the ports in the cycle after the strobe that caused it. It appears both in `global_free` and in the tagged thread's free count, so a lost or doubled update is visible at once. It also shifts when `full` rises: the 32nd insert must raise `full`, and the 33rd must produce `ins_error` one cycle later. A limit that was recomputed wrongly, or recomputed for the wrong threads, appears in `limit_flat` one cycle after the active mask changes. Unchanged limits for inactive and unconfigured threads are read at the same point.

// File: rtl/smt_rob_alloc.sv
module smt_rob_alloc #(
  parameter int NUM_ENTRIES = 32,
  parameter int MAX_THREADS = 4,
  localparam int CW = $clog2(NUM_ENTRIES + 1),
  localparam int TW = (MAX_THREADS > 1) ? $clog2(MAX_THREADS) : 1,
  localparam int NW = $clog2(MAX_THREADS + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [1:0]                  policy,
  input  logic [NW-1:0]               cfg_threads,
  input  logic [MAX_THREADS-1:0]      active_mask,
  input  logic [CW-1:0]               threshold,
  input  logic                        ins_valid,
  input  logic [TW-1:0]               ins_tid,
  input  logic                        ret_valid,
  input  logic [TW-1:0]               ret_tid,
  output logic [MAX_THREADS*CW-1:0]   limit_flat,
  output logic [MAX_THREADS*CW-1:0]   free_flat,
  output logic [CW-1:0]               global_free,
  output logic                        full,
  output logic                        ins_error
);

  localparam logic [1:0] POL_PART = 2'd1;
  localparam logic [1:0] POL_THR  = 2'd2;
  localparam logic [CW-1:0] TOTAL = CW'(NUM_ENTRIES);

  logic [CW-1:0]          occ_q [MAX_THREADS];
  logic [CW-1:0]          lim_q [MAX_THREADS];
  logic [CW-1:0]          lim_nx [MAX_THREADS];
  logic [CW-1:0]          base_lim [MAX_THREADS];
  logic [CW-1:0]          g_occ_q;
  logic [MAX_THREADS-1:0] cfg_mask, eff_mask, prev_mask_q;
  logic                   init_q;
  int                     act_cnt, cfg_cnt;

  function automatic logic [CW-1:0] share(input int n);
    share = (n > 0) ? CW'(NUM_ENTRIES / n) : TOTAL;
  endfunction

  always_comb begin
    for (int t = 0; t < MAX_THREADS; t++)
      cfg_mask[t] = (t < int'(cfg_threads));
    cfg_cnt = (int'(cfg_threads) > MAX_THREADS) ? MAX_THREADS : int'(cfg_threads);
  end

  assign eff_mask = active_mask & cfg_mask;
  assign act_cnt  = $countones(eff_mask);

  always_comb begin
    for (int t = 0; t < MAX_THREADS; t++) begin
      if (!cfg_mask[t])            base_lim[t] = '0;
      else if (policy == POL_PART) base_lim[t] = share(cfg_cnt);
      else if (policy == POL_THR)  base_lim[t] = threshold;
      else                         base_lim[t] = TOTAL;
    end
  end

  always_comb begin
    for (int t = 0; t < MAX_THREADS; t++) begin
      lim_nx[t] = lim_q[t];
      if (init_q)
        lim_nx[t] = base_lim[t];
      else if (eff_mask != prev_mask_q && act_cnt != 0 && eff_mask[t]) begin
        if (policy == POL_PART)
          lim_nx[t] = share(act_cnt);
        else if (policy == POL_THR && act_cnt == 1)
          lim_nx[t] = TOTAL;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q      <= 1'b1;
      prev_mask_q <= '0;
      for (int t = 0; t < MAX_THREADS; t++) lim_q[t] <= '0;
    end else begin
      init_q      <= 1'b0;
      prev_mask_q <= eff_mask;
      for (int t = 0; t < MAX_THREADS; t++) lim_q[t] <= lim_nx[t];
    end
  end

  logic ins_ok, ret_ok, ret_in_range;

  assign full         = (g_occ_q == TOTAL);
  assign global_free  = TOTAL - g_occ_q;
  assign ins_ok       = ins_valid && !full;
  assign ret_in_range = (int'(ret_tid) < MAX_THREADS);
  assign ret_ok       = ret_valid && ret_in_range && (occ_q[ret_tid] != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g_occ_q   <= '0;
      ins_error <= 1'b0;
      for (int t = 0; t < MAX_THREADS; t++) occ_q[t] <= '0;
    end else begin
      ins_error <= ins_valid && full;
      g_occ_q   <= g_occ_q + CW'(ins_ok) - CW'(ret_ok);
      for (int t = 0; t < MAX_THREADS; t++)
        occ_q[t] <= occ_q[t]
                  + CW'(ins_ok && int'(ins_tid) == t)
                  - CW'(ret_ok && int'(ret_tid) == t);
    end
  end

  for (genvar t = 0; t < MAX_THREADS; t++) begin : g_out
    assign limit_flat[t*CW +: CW] = lim_q[t];
    assign free_flat[t*CW +: CW]  = (lim_q[t] > occ_q[t]) ? lim_q[t] - occ_q[t] : '0;
  end

endmodule

module smt_rob_alloc_chk #(
  parameter int CW = 6,
  parameter int TW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ins_valid,
  input logic          ret_valid,
  input logic [CW-1:0] global_free,
  input logic          full,
  input logic          ins_error
);

  assert_full_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    full == (global_free == '0));

  assert_reject_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && full && !ret_valid) |=> (ins_error && global_free == '0));

  assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ins_error |-> $past(ins_valid && full));

  assert_insert_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !full && !ret_valid) |=> (global_free == $past(global_free) - 1'b1));

endmodule

bind smt_rob_alloc smt_rob_alloc_chk #(.CW(CW), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ret_valid(ret_valid),
  .global_free(global_free), .full(full), .ins_error(ins_error)
);

// File: tb/test_smt_rob_alloc.sv
`timescale 1ns/1ps
module test_smt_rob_alloc;
  localparam int N  = 32;
  localparam int T  = 4;
  localparam int CW = 6;

  logic clk = 0, rst_n = 0;
  logic [1:0] policy = 0;
  logic [2:0] cfg_threads = 0;
  logic [T-1:0] active_mask = 0;
  logic [CW-1:0] threshold = 0;
  logic ins_valid = 0, ret_valid = 0;
  logic [1:0] ins_tid = 0, ret_tid = 0;
  logic [T*CW-1:0] limit_flat, free_flat;
  logic [CW-1:0] global_free;
  logic full, ins_error;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  smt_rob_alloc i_smt_rob_alloc (
    .clk(clk), .rst_n(rst_n), .policy(policy), .cfg_threads(cfg_threads),
    .active_mask(active_mask), .threshold(threshold),
    .ins_valid(ins_valid), .ins_tid(ins_tid), .ret_valid(ret_valid), .ret_tid(ret_tid),
    .limit_flat(limit_flat), .free_flat(free_flat), .global_free(global_free),
    .full(full), .ins_error(ins_error)
  );

  function automatic int lim(input int t); return int'(limit_flat[t*CW +: CW]); endfunction
  function automatic int fre(input int t); return int'(free_flat[t*CW +: CW]); endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] pol, input int cfg, input logic [T-1:0] m, input int thr);
    @(negedge clk);
    rst_n = 0; policy = pol; cfg_threads = 3'(cfg); active_mask = m; threshold = CW'(thr);
    ins_valid = 0; ret_valid = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic step(input bit iv, input int it, input bit rv, input int rt);
    ins_valid = iv; ins_tid = 2'(it); ret_valid = rv; ret_tid = 2'(rt);
    @(negedge clk);
    ins_valid = 0; ret_valid = 0;
  endtask

  task automatic set_mask(input logic [T-1:0] m);
    active_mask = m;
    @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst_n = 0; policy = 0; cfg_threads = 4; active_mask = 4'hF;
    @(negedge clk);
    chk("R1 global_free in reset", global_free, N);
    chk("R1 full in reset", full, 0);
    chk("R1 ins_error in reset", ins_error, 0);
    chk("R1 limit0 in reset", lim(0), 0);
    chk("R1 free0 in reset", fre(0), 0);
  endtask

  task automatic t_dynamic;
    do_reset(2'd0, 2, 4'b0011, 0);
    chk("R2 limit0", lim(0), N);
    chk("R2 limit1", lim(1), N);
    chk("R5 limit2 unconfigured", lim(2), 0);
    chk("R5 limit3 unconfigured", lim(3), 0);
    do_reset(2'd3, 1, 4'b0001, 0);
    chk("R2 code3 limit0", lim(0), N);
  endtask

  task automatic t_partitioned;
    do_reset(2'd1, 3, 4'b0111, 0);
    chk("R3 limit0", lim(0), 10);
    chk("R3 limit2", lim(2), 10);
    chk("R5 limit3", lim(3), 0);
    set_mask(4'b0001);
    chk("R6 single active limit0", lim(0), N);
    chk("R6 inactive limit1 kept", lim(1), 10);
    set_mask(4'b0011);
    chk("R6 two active limit0", lim(0), 16);
    chk("R6 two active limit1", lim(1), 16);
    chk("R6 inactive limit2 kept", lim(2), 10);
    set_mask(4'b0000);
    chk("R7 empty set limit0 kept", lim(0), 16);
    chk("R7 empty set limit2 kept", lim(2), 10);
  endtask

  task automatic t_threshold;
    do_reset(2'd2, 4, 4'b1111, 7);
    chk("R4 limit0", lim(0), 7);
    chk("R4 limit3", lim(3), 7);
    set_mask(4'b0100);
    chk("R7 single active limit2", lim(2), N);
    chk("R7 other limit1 kept", lim(1), 7);
    set_mask(4'b0110);
    chk("R7 two active limit2 kept", lim(2), N);
    chk("R7 two active limit1 kept", lim(1), 7);
  endtask

  task automatic t_counting;
    do_reset(2'd0, 4, 4'b1111, 0);
    for (int i = 0; i < 3; i++) step(1, 1, 0, 0);
    chk("R8 free1 after 3 inserts", fre(1), 29);
    chk("R9 global_free after 3 inserts", global_free, 29);
    step(0, 0, 1, 1);
    chk("R8 free1 after retire", fre(1), 30);
    chk("R8 global_free after retire", global_free, 30);
    step(1, 1, 1, 1);
    chk("R11 same-thread pair free1", fre(1), 30);
    chk("R11 same-thread pair global", global_free, 30);
    step(1, 0, 1, 1);
    chk("R11 cross pair free0", fre(0), 31);
    chk("R11 cross pair free1", fre(1), 31);
    chk("R11 cross pair global", global_free, 30);
    step(0, 0, 1, 2);
    chk("R8 retire empty thread global", global_free, 30);
    chk("R8 retire empty thread free2", fre(2), N);
  endtask

  task automatic t_full;
    do_reset(2'd0, 4, 4'b1111, 0);
    for (int i = 0; i < N; i++) step(1, 0, 0, 0);
    chk("R9 full at capacity", full, 1);
    chk("R9 global_free at capacity", global_free, 0);
    chk("R10 no error before overflow", ins_error, 0);
    step(1, 1, 0, 0);
    chk("R10 error after rejected insert", ins_error, 1);
    chk("R10 free1 unchanged", fre(1), N);
    chk("R10 global unchanged", global_free, 0);
    @(negedge clk);
    chk("R10 error clears", ins_error, 0);
    step(0, 0, 1, 3);
    chk("R8 retire empty thread when full", global_free, 0);
    step(0, 0, 1, 0);
    chk("R9 full drops after retire", full, 0);
    chk("R9 global_free after retire", global_free, 1);
  endtask

  task automatic t_saturate;
    do_reset(2'd1, 2, 4'b0011, 0);
    chk("R3 two threads limit0", lim(0), 16);
    set_mask(4'b0001);
    chk("R6 grow limit0", lim(0), N);
    for (int i = 0; i < 20; i++) step(1, 0, 0, 0);
    chk("R12 free0 before shrink", fre(0), 12);
    set_mask(4'b0011);
    chk("R6 shrink limit0", lim(0), 16);
    chk("R12 free0 saturates", fre(0), 0);
    set_mask(4'b1111);
    chk("R5 unconfigured bits ignored limit0", lim(0), 16);
    chk("R5 unconfigured limit3", lim(3), 0);
  endtask

  initial begin
    t_reset();
    t_dynamic();
    t_partitioned();
    t_threshold();
    t_counting();
    t_full();
    t_saturate();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule